// File: doc/BRIEF.md
# Serial Control Register Port for an Audio Clock Generator

This block is the control front end of a clock generator that produces audio system clocks from a video-rate master clock. A host writes 16-bit command words over three wires: a serial data line, a bit clock and a latch strobe. The upper six bits of each word are an address. The address picks one of two internal registers, and the remaining ten bits are its payload. The block drives the decoded control fields as plain level outputs to the clock dividers and output buffers: a frequency-group code, a rate code, six output enables, a power-down flag and a two-bit selector for the variable-rate clock output.

All three serial inputs are asynchronous to the master clock. They are resynchronized inside the block, and every decision is taken in the master-clock domain. After reset an internal counter holds the registers at their defaults for a fixed number of master clocks. Only then does the port start to accept words. When every output enable is cleared, power-down is flagged, but the serial port keeps running so that a later write can wake the device. The block has no data stream, so no valid/ready handshake appears at its edge. All pins are plain levels, and the host paces itself by the serial timing rules.

Top module: `sctl_port`

## Requirements
- R1: From reset release until RST_CYCLES master clocks have elapsed, the outputs hold their defaults and any serial word is ignored. The defaults are clk_en = 6'b111111, fs_grp = 2'b00, rate_sel = 2'b00, var_sel[1] = 0 and pwr_dn = 0.
- R2: While the strobe is low, one data bit is taken on each rising edge of the bit clock, most significant bit first. The last 16 bits taken form the word, with bit 15 as the first bit sent.
- R3: A word whose bits 15..10 are 6'b011100 writes the mode register. Bits 9..4 go to clk_en[5:0], bits 3..2 go to rate_sel and bits 1..0 go to fs_grp. clk_en[0] enables the fixed clock, [1] the 256x clock, [2] the 384x clock, [3] the variable clock, [4] master copy 1 and [5] master copy 2. The fs_grp codes are 00 = 48 kHz group, 01 = 44.1 kHz and 10 = 32 kHz. The rate_sel codes are 00 = standard, 01 = double and 10 = half. The reserved code 11 is stored as written in either field.
- R4: A word whose bits 15..10 are 6'b011011 writes only the configuration bit, taken from word bit 4. The other payload bits are ignored, and the mode register is not changed.
- R5: A word with any other address leaves every output unchanged.
- R6: A rising strobe edge commits a word only if at least 16 bits arrived since the strobe last fell. With fewer bits the strobe edge is ignored. With more bits, the last 16 are used.
- R7: pwr_dn is 1 exactly when all six enables are 0. A mode write received during power-down is still applied and can clear pwr_dn.
- R8: var_sel = {configuration bit, csel_pin}. Code 00 selects 36.864 MHz, 01 selects 24.576 MHz, 10 selects 18.432 MHz and 11 selects 12.288 MHz. Bit 0 follows the pin with no clocking.
- R9: A committed write appears at the outputs after the third rising master-clock edge that follows the strobe rising edge. It does not appear after the second edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_m | input | 1 | Master clock; must run at least 4x the serial bit clock |
| rst_n | input | 1 | Active-low asynchronous reset; starts the default-hold window |
| ser_dat | input | 1 | Serial data, asynchronous |
| ser_bclk | input | 1 | Serial bit clock, data taken on its rising edge |
| ser_latch | input | 1 | Latch strobe; low while shifting, rising edge commits |
| csel_pin | input | 1 | Hardware select bit for the variable clock |
| fs_grp | output | 2 | Sampling frequency group code |
| rate_sel | output | 2 | Sampling rate code |
| clk_en | output | 6 | Per-output clock enables |
| pwr_dn | output | 1 | Power-down request, all enables clear |
| var_sel | output | 2 | Variable clock frequency selector |

## Verification
A corrupted bit counter or a shifted word shows up at the next strobe rising edge: a short word is applied, a full word is dropped, or the fields are permuted. The damage is visible three master clocks after that edge. A wrong address decode shows up as a write landing in the wrong register, for example var_sel moving on a mode word or the enables moving on a configuration word. A reset window of the wrong length shows up as early or lost writes near the RST_CYCLES boundary. The reference model tracks every clock, so any of these faults shows as a mismatch in the first cycle the outputs differ.

// File: rtl/sctl_pkg.sv
package sctl_pkg;
  localparam int WORD_W   = 16;
  localparam int ADDR_W   = 6;
  localparam int CE_W     = 6;
  localparam int PAY_W    = WORD_W - ADDR_W;
  localparam int CFG_BIT  = 4;

  // indices of the synchronized serial inputs
  localparam int SIG_DAT  = 0;
  localparam int SIG_BCLK = 1;
  localparam int SIG_LAT  = 2;
  localparam int SIG_N    = 3;

  localparam logic [ADDR_W-1:0] ADDR_MODE = 6'b011100;
  localparam logic [ADDR_W-1:0] ADDR_CFG  = 6'b011011;

  typedef enum logic [1:0] {
    FSG_48K  = 2'b00,
    FSG_44K1 = 2'b01,
    FSG_32K  = 2'b10,
    FSG_RSV  = 2'b11
  } fs_grp_e;

  typedef enum logic [1:0] {
    RATE_STD  = 2'b00,
    RATE_DBL  = 2'b01,
    RATE_HALF = 2'b10,
    RATE_RSV  = 2'b11
  } rate_e;

  // packed layout mirrors payload bits 9..0 of a mode word
  typedef struct packed {
    logic [CE_W-1:0] ce;
    logic [1:0]      sr;
    logic [1:0]      fs;
  } mode_t;

  localparam mode_t MODE_DEFAULT = '{ce: {CE_W{1'b1}}, sr: RATE_STD, fs: FSG_48K};
  localparam logic  CFG_DEFAULT  = 1'b0;
endpackage

// File: rtl/sctl_sync.sv
module sctl_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw,
  output logic [N-1:0] lvl,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  localparam int SW = (STAGES < 2) ? 2 : STAGES;

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic [SW-1:0] chain;
    logic          prev;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain <= '0;
        prev  <= 1'b0;
      end else begin
        chain <= {chain[SW-2:0], raw[i]};
        prev  <= chain[SW-1];
      end
    end

    assign lvl[i]  = chain[SW-1];
    assign rise[i] = chain[SW-1] & ~prev;
    assign fall[i] = ~chain[SW-1] & prev;
  end
endmodule

// File: rtl/sctl_init.sv
module sctl_init #(
  parameter int CYCLES = 1024
) (
  input  logic clk,
  input  logic rst_n,
  output logic done
);
  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (!done) begin
      cnt <= cnt + 1'b1;
      if (cnt == LAST) done <= 1'b1;
    end
  end
endmodule

// File: rtl/sctl_shift.sv
module sctl_shift #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         bit_stb,
  input  logic         bit_val,
  input  logic         lat_lvl,
  input  logic         lat_fall,
  input  logic         lat_rise,
  output logic [W-1:0] word,
  output logic         commit
);
  localparam int CNT_W = $clog2(W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(W);

  logic [CNT_W-1:0] nbits;
  logic             full;

  assign full   = (nbits == FULL);
  assign commit = en & lat_rise & full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word  <= '0;
      nbits <= '0;
    end else if (en) begin
      if (lat_fall) begin
        nbits <= '0;
      end else if (bit_stb && !lat_lvl) begin
        word <= {word[W-2:0], bit_val};
        if (!full) nbits <= nbits + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sctl_regs.sv
module sctl_regs
  import sctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_done,
  input  logic              commit,
  input  logic [WORD_W-1:0] word,
  output mode_t             mode_q,
  output logic              cfg_q
);
  logic [ADDR_W-1:0] addr;
  logic [PAY_W-1:0]  pay;

  assign addr = word[WORD_W-1 -: ADDR_W];
  assign pay  = word[PAY_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_DEFAULT;
      cfg_q  <= CFG_DEFAULT;
    end else if (!init_done) begin
      mode_q <= MODE_DEFAULT;
      cfg_q  <= CFG_DEFAULT;
    end else if (commit) begin
      case (addr)
        ADDR_MODE: mode_q <= mode_t'(pay);
        ADDR_CFG:  cfg_q  <= pay[CFG_BIT];
        default:   ;
      endcase
    end
  end
endmodule

// File: rtl/sctl_port.sv
module sctl_port
  import sctl_pkg::*;
#(
  parameter int RST_CYCLES  = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk_m,
  input  logic            rst_n,
  input  logic            ser_dat,
  input  logic            ser_bclk,
  input  logic            ser_latch,
  input  logic            csel_pin,
  output logic [1:0]      fs_grp,
  output logic [1:0]      rate_sel,
  output logic [CE_W-1:0] clk_en,
  output logic            pwr_dn,
  output logic [1:0]      var_sel
);
  logic [SIG_N-1:0]  lvl_w, rise_w, fall_w;
  logic              init_done;
  logic [WORD_W-1:0] word_w;
  logic              commit_w;
  mode_t             mode_w;
  logic              cfg_w;
  logic              sync_unused;

  sctl_sync #(.N(SIG_N), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk_m),
    .rst_n(rst_n),
    .raw  ({ser_latch, ser_bclk, ser_dat}),
    .lvl  (lvl_w),
    .rise (rise_w),
    .fall (fall_w)
  );

  assign sync_unused = ^{rise_w[SIG_DAT], fall_w[SIG_DAT], fall_w[SIG_BCLK], lvl_w[SIG_BCLK]};

  sctl_init #(.CYCLES(RST_CYCLES)) u_init (
    .clk  (clk_m),
    .rst_n(rst_n),
    .done (init_done)
  );

  sctl_shift #(.W(WORD_W)) u_shift (
    .clk     (clk_m),
    .rst_n   (rst_n),
    .en      (init_done),
    .bit_stb (rise_w[SIG_BCLK]),
    .bit_val (lvl_w[SIG_DAT]),
    .lat_lvl (lvl_w[SIG_LAT]),
    .lat_fall(fall_w[SIG_LAT]),
    .lat_rise(rise_w[SIG_LAT]),
    .word    (word_w),
    .commit  (commit_w)
  );

  sctl_regs u_regs (
    .clk      (clk_m),
    .rst_n    (rst_n),
    .init_done(init_done),
    .commit   (commit_w),
    .word     (word_w),
    .mode_q   (mode_w),
    .cfg_q    (cfg_w)
  );

  assign fs_grp   = mode_w.fs;
  assign rate_sel = mode_w.sr;
  assign clk_en   = mode_w.ce;
  assign pwr_dn   = ~|mode_w.ce;
  assign var_sel  = {cfg_w, csel_pin};
endmodule

// File: rtl/sctl_port_chk.sv
module sctl_port_chk
  import sctl_pkg::*;
#(
  parameter int RST_CYCLES = 1024,
  parameter int W          = 16
) (
  input logic            clk_m,
  input logic            rst_n,
  input logic [CE_W-1:0] clk_en,
  input logic [1:0]      fs_grp,
  input logic [1:0]      rate_sel,
  input logic            pwr_dn,
  input logic            var_hi,
  input logic            commit_v,
  input logic [W-1:0]    word,
  input logic            bclk_rise,
  input logic            lat_lvl,
  input logic            lat_fall
);
  localparam int IW = $clog2(RST_CYCLES + 2);
  localparam int BW = $clog2(W + 1);

  logic [IW-1:0] ck_init;
  logic [BW-1:0] ck_bits;

  always_ff @(posedge clk_m or negedge rst_n) begin
    if (!rst_n) begin
      ck_init <= '0;
      ck_bits <= '0;
    end else begin
      if (int'(ck_init) < RST_CYCLES) ck_init <= ck_init + 1'b1;
      if (lat_fall) ck_bits <= '0;
      else if (bclk_rise && !lat_lvl && int'(ck_bits) < W) ck_bits <= ck_bits + 1'b1;
    end
  end

  AST_INIT_DEFAULTS: assert property (@(posedge clk_m) disable iff (!rst_n)
    (int'(ck_init) < RST_CYCLES) |-> (clk_en == {CE_W{1'b1}} && fs_grp == 2'b00 &&
                                      rate_sel == 2'b00 && !var_hi && !pwr_dn)); // R1

  AST_MODE_ONLY_ON_MODE_WORD: assert property (@(posedge clk_m) disable iff (!rst_n)
    !$stable({clk_en, fs_grp, rate_sel}) |-> $past(commit_v && word[W-1 -: ADDR_W] == ADDR_MODE)); // R3

  AST_CFG_ONLY_ON_CFG_WORD: assert property (@(posedge clk_m) disable iff (!rst_n)
    !$stable(var_hi) |-> $past(commit_v && word[W-1 -: ADDR_W] == ADDR_CFG)); // R4

  AST_SHORT_WORD_DROPPED: assert property (@(posedge clk_m) disable iff (!rst_n)
    commit_v |-> (int'(ck_bits) == W)); // R6

  AST_PWRDN_FROM_ZERO_WORD: assert property (@(posedge clk_m) disable iff (!rst_n)
    $rose(pwr_dn) |-> $past(commit_v && word[PAY_W-1 -: CE_W] == '0)); // R7

  AST_COMMIT_SINGLE_PULSE: assert property (@(posedge clk_m) disable iff (!rst_n)
    commit_v |=> !commit_v); // R9
endmodule

bind sctl_port sctl_port_chk #(.RST_CYCLES(RST_CYCLES), .W(sctl_pkg::WORD_W)) u_chk (
  .clk_m    (clk_m),
  .rst_n    (rst_n),
  .clk_en   (clk_en),
  .fs_grp   (fs_grp),
  .rate_sel (rate_sel),
  .pwr_dn   (pwr_dn),
  .var_hi   (var_sel[1]),
  .commit_v (commit_w),
  .word     (word_w),
  .bclk_rise(rise_w[sctl_pkg::SIG_BCLK]),
  .lat_lvl  (lvl_w[sctl_pkg::SIG_LAT]),
  .lat_fall (fall_w[sctl_pkg::SIG_LAT])
);

// File: tb/sctl_port_tb.sv
module sctl_port_tb;
  localparam int RST = 1024;
  localparam int HB  = 4; // master clocks per bit-clock half period

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dat = 1'b0, bclk = 1'b0, lat = 1'b1, csel = 1'b0;
  logic [1:0] fs_grp, rate_sel, var_sel;
  logic [5:0] clk_en;
  logic       pwr_dn;

  int errors = 0;
  int checks = 0;
  bit fin = 1'b0;

  always #5 clk = ~clk;

  sctl_port u_dut (
    .clk_m(clk), .rst_n(rst_n), .ser_dat(dat), .ser_bclk(bclk), .ser_latch(lat),
    .csel_pin(csel), .fs_grp(fs_grp), .rate_sel(rate_sel), .clk_en(clk_en),
    .pwr_dn(pwr_dn), .var_sel(var_sel)
  );

  // behavioural reference: inputs seen two clocks late, word committed on a late strobe rise
  logic q1d, q2d, q3d, q1b, q2b, q3b, q1l, q2l, q3l;
  int   since, m_cnt;
  logic [15:0] m_word;
  logic [5:0]  m_ce;
  logic [1:0]  m_sr, m_fs;
  logic        m_cfg;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {q1d, q2d, q3d, q1b, q2b, q3b, q1l, q2l, q3l} = '0;
      since = 0; m_cnt = 0; m_word = '0;
      m_ce = 6'h3F; m_sr = 2'b00; m_fs = 2'b00; m_cfg = 1'b0;
    end else begin
      if (since >= RST) begin
        if (q2l && !q3l && m_cnt >= 16) begin
          if (m_word[15:10] == 6'b011100) begin
            m_ce = m_word[9:4]; m_sr = m_word[3:2]; m_fs = m_word[1:0];
          end else if (m_word[15:10] == 6'b011011) begin
            m_cfg = m_word[4];
          end
        end
        if (!q2l && q3l) m_cnt = 0;
        else if (q2b && !q3b && !q2l) begin
          m_word = {m_word[14:0], q2d};
          if (m_cnt < 16) m_cnt++;
        end
      end
      if (since < RST) since++;
      q3d = q2d; q2d = q1d; q1d = dat;
      q3b = q2b; q2b = q1b; q1b = bclk;
      q3l = q2l; q2l = q1l; q1l = lat;
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // every-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !fin) begin
      chk("R3 clk_en model", {10'd0, clk_en}, {10'd0, m_ce});
      chk("R3 fs_grp model", {14'd0, fs_grp}, {14'd0, m_fs});
      chk("R3 rate_sel model", {14'd0, rate_sel}, {14'd0, m_sr});
      chk("R7 pwr_dn model", {15'd0, pwr_dn}, {15'd0, (m_ce == 6'd0)});
      chk("R8 var_sel model", {14'd0, var_sel}, {14'd0, m_cfg, csel});
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [31:0] v, input int nbits);
    @(negedge clk);
    lat = 1'b0;
    wait_n(HB);
    for (int i = nbits - 1; i >= 0; i--) begin
      dat = v[i];
      wait_n(HB);
      bclk = 1'b1;
      wait_n(HB);
      bclk = 1'b0;
    end
    wait_n(HB);
    lat = 1'b1;
  endtask

  function automatic logic [15:0] mw(input logic [5:0] ce, input logic [1:0] sr, input logic [1:0] fs);
    return {6'b011100, ce, sr, fs};
  endfunction

  function automatic logic [15:0] cw(input logic c);
    return {6'b011011, 5'b00000, c, 4'b0000};
  endfunction

  task automatic chk_all(input string tag, input logic [5:0] ce, input logic [1:0] sr,
                         input logic [1:0] fs, input logic pd);
    chk({tag, " clk_en"}, {10'd0, clk_en}, {10'd0, ce});
    chk({tag, " rate_sel"}, {14'd0, rate_sel}, {14'd0, sr});
    chk({tag, " fs_grp"}, {14'd0, fs_grp}, {14'd0, fs});
    chk({tag, " pwr_dn"}, {15'd0, pwr_dn}, {15'd0, pd});
  endtask

  initial begin
    #(200000 * 10);
    if (!fin) begin
      fin = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    wait_n(5);
    rst_n = 1'b1;
    wait_n(3);
    chk_all("R1 reset defaults", 6'h3F, 2'b00, 2'b00, 1'b0);
    chk("R1 var_sel default", {14'd0, var_sel}, 16'h0000);

    // R1: a word sent during the default-hold window is lost
    send({16'd0, mw(6'h00, 2'b01, 2'b01)}, 16);
    wait_n(24);
    chk_all("R1 write during init ignored", 6'h3F, 2'b00, 2'b00, 1'b0);
    wait_n(RST);
    chk_all("R1 defaults after init", 6'h3F, 2'b00, 2'b00, 1'b0);

    // R2/R3/R9: mode write, latency of three master-clock edges
    send({16'd0, mw(6'b101010, 2'b01, 2'b10)}, 16);
    wait_n(2);
    chk("R9 old value after two edges", {14'd0, fs_grp}, 16'h0000);
    wait_n(1);
    chk("R9 new value after third edge", {14'd0, fs_grp}, 16'h0002);
    chk("R2 msb-first enables", {10'd0, clk_en}, 16'h002A);
    chk_all("R3 mode write", 6'b101010, 2'b01, 2'b10, 1'b0);
    wait_n(20);

    // R4: configuration write leaves mode untouched
    send({16'd0, cw(1'b1)}, 16);
    wait_n(24);
    chk("R4 cfg bit", {14'd0, var_sel}, 16'h0002);
    chk_all("R4 mode untouched", 6'b101010, 2'b01, 2'b10, 1'b0);

    // R8: pin combines without a clock edge
    csel = 1'b1;
    #1;
    chk("R8 pin passes through", {14'd0, var_sel}, 16'h0003);
    send({16'd0, cw(1'b0)}, 16);
    wait_n(24);
    chk("R8 cfg cleared with pin high", {14'd0, var_sel}, 16'h0001);

    // R5: unknown addresses
    send({16'd0, 16'hFC3F}, 16);
    wait_n(24);
    send({16'd0, 6'b011101, 10'h3F0}, 16);
    wait_n(24);
    chk_all("R5 unknown address ignored", 6'b101010, 2'b01, 2'b10, 1'b0);
    chk("R5 var_sel unchanged", {14'd0, var_sel}, 16'h0001);

    // R6: short word dropped, long word keeps last 16 bits
    send({20'd0, mw(6'h3F, 2'b00, 2'b00) >> 4}, 12);
    wait_n(24);
    chk_all("R6 short word ignored", 6'b101010, 2'b01, 2'b10, 1'b0);
    send({12'd0, 4'b1011, mw(6'b010101, 2'b10, 2'b01)}, 20);
    wait_n(24);
    chk_all("R6 long word last 16", 6'b010101, 2'b10, 2'b01, 1'b0);

    // R7: power-down and wake
    send({16'd0, mw(6'h00, 2'b00, 2'b00)}, 16);
    wait_n(24);
    chk_all("R7 power-down", 6'h00, 2'b00, 2'b00, 1'b1);
    send({16'd0, mw(6'h3F, 2'b00, 2'b00)}, 16);
    wait_n(24);
    chk_all("R7 wake", 6'h3F, 2'b00, 2'b00, 1'b0);

    // R3: reserved codes stored as written
    send({16'd0, mw(6'h01, 2'b11, 2'b11)}, 16);
    wait_n(24);
    chk_all("R3 reserved codes", 6'h01, 2'b11, 2'b11, 1'b0);

    fin = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule